// File: doc/BRIEF.md
# Mode-Selected Signed ALU with Condition Flags

This block is the arithmetic/logic stage of a small 16-bit teaching processor. Each cycle it combines two operand words under a 3-bit mode code and drives a combinational primary result. A second output carries the upper half of a full signed product. The eight modes are: idle, add, subtract, multiply, NAND, logical shift left, logical shift right and a flag probe.

Two condition flags, zero and negative, sit in a register. That register uses the clock and the synchronous active-high reset of the surrounding register file. Only the probe mode updates the flags. Every other mode leaves them untouched, so a later instruction can still read the condition that the last probe recorded.

Top module: `alu16_flagged`

## Requirements
- R1: Mode code 3'd0 (idle) drives both the primary result and the upper output to zero.
- R2: Mode 3'd1 gives the low 16 bits of opa + opb. Mode 3'd2 gives the low 16 bits of opa - opb. Both treat the operands as two's-complement.
- R3: Mode 3'd3 forms the 32-bit signed product opa*opb. Bits 15:0 go on the primary result and bits 31:16 go on the upper output.
- R4: Mode 3'd4 gives the bitwise NOT of (opa AND opb).
- R5: Mode 3'd5 shifts opa left by opb[3:0] positions and fills the vacated bits with zeros. Bits 15:4 of opb have no effect.
- R6: Mode 3'd6 shifts opa right by opb[3:0] positions and fills the vacated bits with zeros, including when bit 15 is set.
- R7: In mode 3'd7 the primary result is zero. On the next rising clock edge the zero flag becomes (opa == 0) and the negative flag becomes opa[15].
- R8: In every mode other than 3'd7 both flags keep their previous value across the clock edge.
- R9: The upper output is zero in every mode except 3'd3.
- R10: A synchronous active-high reset clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the register file |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operation select |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (shift amount in bits 3:0) |
| res | output | 16 | Primary result |
| res_hi | output | 16 | Upper half of the product |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
The bench builds the block with its defaults: a 16-bit word and a 4-bit shift field. At this size the sign boundaries are within reach of directed tests: 0x7FFF+1 overflow, the 0x8000 times -1 product and a most-negative operand in a right shift. Each of the 16 shift distances is also within reach. The flags are checked across sequences that mix probe and non-probe modes, so flag retention shows at the flag ports.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_MUL  = 3'd3,
    OP_NAND = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PROBE = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          dir_right,
  output logic [W-1:0]  dout
);
  localparam int STAGES = SW;
  logic [W-1:0] stage [STAGES+1];

  assign stage[0] = din;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int D = 1 << s;
    always_comb begin
      if (!amt[s])
        stage[s+1] = stage[s];
      else if (dir_right)
        stage[s+1] = stage[s] >> D;
      else
        stage[s+1] = stage[s] << D;
    end
  end
  assign dout = stage[STAGES];

  always_comb begin
    if (amt == '0)
      AST_SHIFT_ZERO_PASS: assert (dout == din); // R5
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] probe_val,
  output logic         fz,
  output logic         fn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fz <= 1'b0;
      fn <= 1'b0;
    end else if (upd) begin
      fz <= (probe_val == '0);
      fn <= probe_val[W-1];
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(fz) && $stable(fn))); // R8
  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (rst)
    upd |=> (fn == $past(probe_val[W-1]))); // R7
  AST_FLAGS_RESET: assert property (@(posedge clk)
    rst |=> (!fz && !fn)); // R10
endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic [W-1:0] res_hi,
  output logic         flag_z,
  output logic         flag_n
);
  import alu16_pkg::*;
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = PW'(signed'(a));
    eb = PW'(signed'(b));
    return PW'(ea * eb);
  endfunction

  function automatic logic [W-1:0] nand_w(input logic [W-1:0] a, input logic [W-1:0] b);
    return ~(a & b);
  endfunction

  alu_op_e op;
  assign op = alu_op_e'(mode);

  logic [PW-1:0] prod;
  logic [W-1:0]  sh_out;
  logic          probe_evt;
  logic          mul_evt;

  assign prod      = smul(opa, opb);
  assign probe_evt = (op == OP_PROBE);
  assign mul_evt   = (op == OP_MUL);

  alu16_shifter #(.W(W), .SW(SW)) u_shift (
    .din(opa), .amt(opb[SW-1:0]), .dir_right(op == OP_SHR), .dout(sh_out)
  );

  alu16_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .upd(probe_evt), .probe_val(opa),
    .fz(flag_z), .fn(flag_n)
  );

  always_comb begin
    res    = '0;
    res_hi = '0;
    unique case (op)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_MUL: begin
        res    = prod[W-1:0];
        res_hi = prod[PW-1:W];
      end
      OP_NAND: res = nand_w(opa, opb);
      OP_SHL, OP_SHR: res = sh_out;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (!mul_evt)
      AST_HI_ONLY_MUL: assert (res_hi == '0); // R9
    if (op == OP_IDLE)
      AST_IDLE_ZERO: assert (res == '0); // R1
    if (probe_evt)
      AST_PROBE_RES_ZERO: assert (res == '0); // R7
  end
endmodule

// File: tb/alu16_flagged_bench.sv
module alu16_flagged_bench;
  logic clk = 0, rst = 1;
  logic [2:0] mode = 0;
  logic [15:0] opa = 0, opb = 0;
  logic [15:0] res, res_hi;
  logic flag_z, flag_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  alu16_flagged u_alu16_flagged (.clk(clk), .rst(rst), .mode(mode), .opa(opa), .opb(opb),
    .res(res), .res_hi(res_hi), .flag_z(flag_z), .flag_n(flag_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    mode = m; opa = a; opb = b;
    #1;
  endtask

  task automatic t_reset;
    rst = 1; apply(3'd0, 0, 0);
    @(posedge clk); #1; rst = 0; #1;
    chk("R10 z", flag_z, 0); chk("R10 n", flag_n, 0);
    chk("R1 res", res, 0); chk("R1 hi", res_hi, 0);
  endtask

  task automatic t_addsub;
    apply(3'd1, 16'h7FFF, 16'h0001); chk("R2 add ovf", res, 16'h8000); chk("R9 add hi", res_hi, 0);
    apply(3'd1, 16'hFFFE, 16'h0005); chk("R2 add neg", res, 16'h0003);
    apply(3'd2, 16'h0003, 16'h0005); chk("R2 sub", res, 16'hFFFE);
    apply(3'd2, 16'h8000, 16'h0001); chk("R2 sub wrap", res, 16'h7FFF);
    apply(3'd0, 16'h1234, 16'h5678); chk("R1 idle", res, 0); chk("R1 idle hi", res_hi, 0);
  endtask

  task automatic t_mul;
    logic signed [31:0] p;
    int vals_a[4] = '{-3, 32767, -32768, 255};
    int vals_b[4] = '{7, 32767, -1, -256};
    for (int i = 0; i < 4; i++) begin
      p = 32'(vals_a[i] * vals_b[i]);
      apply(3'd3, 16'(vals_a[i]), 16'(vals_b[i]));
      chk("R3 lo", res, {16'h0, p[15:0]});
      chk("R3 hi", res_hi, {16'h0, p[31:16]});
    end
  endtask

  task automatic t_nand;
    apply(3'd4, 16'hF0F0, 16'hFF00); chk("R4 nand", res, 16'h0FFF);
    apply(3'd4, 16'hFFFF, 16'hFFFF); chk("R4 nand ones", res, 16'h0000);
  endtask

  task automatic t_shift;
    logic [15:0] e;
    for (int k = 0; k < 16; k++) begin
      e = 16'hA5C3;
      for (int j = 0; j < k; j++) e = {e[14:0], 1'b0};
      apply(3'd5, 16'hA5C3, 16'(k) | 16'hFFF0);
      chk("R5 shl", res, e);
      e = 16'h8001;
      for (int j = 0; j < k; j++) e = {1'b0, e[15:1]};
      apply(3'd6, 16'h8001, 16'(k) | 16'h5A30);
      chk("R6 shr", res, e);
      chk("R9 shift hi", res_hi, 0);
    end
  endtask

  task automatic t_flags;
    apply(3'd7, 16'h0000, 16'h1111); chk("R7 probe res", res, 0); chk("R9 probe hi", res_hi, 0);
    @(posedge clk); #1;
    chk("R7 z set", flag_z, 1); chk("R7 n clr", flag_n, 0);
    apply(3'd1, 16'h8000, 16'h0000); @(posedge clk); #1;
    chk("R8 z hold", flag_z, 1); chk("R8 n hold", flag_n, 0);
    apply(3'd7, 16'h8000, 0); @(posedge clk); #1;
    chk("R7 z clr", flag_z, 0); chk("R7 n set", flag_n, 1);
    apply(3'd2, 16'h0000, 0); @(posedge clk); #1;
    apply(3'd0, 16'h0000, 0); @(posedge clk); #1;
    apply(3'd3, 16'h0000, 0); @(posedge clk); #1;
    chk("R8 z hold2", flag_z, 0); chk("R8 n hold2", flag_n, 1);
    apply(3'd7, 16'h0042, 0); @(posedge clk); #1;
    chk("R7 pos z", flag_z, 0); chk("R7 pos n", flag_n, 0);
    apply(3'd7, 16'h0000, 0); @(posedge clk); #1;
    rst = 1; @(posedge clk); #1; rst = 0;
    chk("R10 z clr", flag_z, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_addsub();
    t_mul();
    t_nand();
    t_shift();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule